// File: doc/BRIEF.md
# Scan Queue Trigger Overrun Tracker

This block follows the execution condition of two conversion scan queues and flags triggers that arrive when a queue cannot take them. Each queue has its own trigger mode, a hardware trigger pulse, a software start pulse and a set of control events: pause, end-of-scan and stop. Queue 1 has priority. When it starts, it parks a running queue 2 as suspended. A queue 2 trigger that arrives while queue 1 is busy is held as pending. The two queue conditions are packed into one 4-bit read-only status code.

A hardware trigger can arrive while its queue is running, suspended or already pending. When that happens the trigger is dropped and the queue's sticky overrun flag is set. The flag does not change how the queue runs. In gated mode, queue 1 also sets its flag when it reaches the end of its scan list for the second time in one run. Software clears a flag in two steps: it reads the register while the flag shows 1, and in a later cycle it writes 0 to that flag's bit. The block carries no data stream, so every pin is a plain control or status signal with no back-pressure.

Top module: `scanq_ovr_tracker`

## Requirements
- R1: After reset both queues are idle, `status_o` is 4'b0000, `ovr_o` is 2'b00 and `rdata_o` is 8'h00.
- R2: Mode codes: 0 off, 1 software single, 2 software continuous, 3 external single, 4 external continuous, 5 timer single, 6 timer continuous, 7 gated. An accepted start moves an idle queue to active. The start is a trigger in modes 3 to 7 and `start_i` in modes 1 and 2. `pause_i` moves an active queue to paused, and an accepted start resumes it. `stop_i` returns the queue to idle. End-of-scan returns an active queue to idle, except in mode 2 and in mode 7 on queue 1, where the queue stays active.
- R3: When queue 1 leaves idle while queue 2 is active, queue 2 becomes suspended. A start accepted by queue 2 while queue 1 is not idle makes queue 2 pending. A suspended or pending queue 2 becomes active in the cycle that queue 1 returns to idle. Queue 1 is never suspended or pending.
- R4: The status code is {q1 field, q2 field}. The q1 field is 00 for idle, 01 for active and 10 for paused. When queue 1 is idle, the q2 field is 00 for idle, 01 for active and 10 for paused. Otherwise the q2 field is 00 for idle, 01 for paused, 10 for suspended and 11 for pending. Codes 4'b0011 and 4'b11xx never appear.
- R5: In modes 3 to 7, a trigger that arrives while the queue is active, suspended or pending sets that queue's flag (`ovr_o[0]` for queue 1, `ovr_o[1]` for queue 2). A trigger that arrives in idle or paused is accepted and sets no flag.
- R6: In modes 0, 1 and 2, triggers never set a flag or change state. In modes 0 and 3 to 7, `start_i` has no effect.
- R7: A trigger that causes an overrun leaves the queue's state unchanged and is not remembered.
- R8: In mode 7, queue 1 sets its flag on the second and each later end-of-scan of one run. The count starts again when the queue returns to idle.
- R9: A write with `wdata_i[k]`=0 clears flag k if, in an earlier cycle since the flag last set, a read (`rd_i`) saw that flag as 1.
- R10: A write of 0 to a flag that has not been read as 1 since it set leaves the flag set. Writing 1 never changes a flag.
- R11: When an overrun and a clearing write hit the same flag in the same cycle, the flag stays set, and a new read is needed before a write can clear it.
- R12: `rdata_o` is {status code, 2'b00, `ovr_o`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q1_mode_i | input | 3 | Queue 1 trigger mode |
| q2_mode_i | input | 3 | Queue 2 trigger mode |
| trig_i | input | 2 | Hardware trigger pulses, bit 0 for queue 1 |
| start_i | input | 2 | Software start pulses |
| pause_i | input | 2 | Pause events |
| eoq_i | input | 2 | End-of-scan events |
| stop_i | input | 2 | Stop/completion events |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 2 | Write data, one bit per flag |
| rdata_o | output | 8 | Register read data |
| status_o | output | 4 | Encoded queue status |
| ovr_o | output | 2 | Sticky overrun flags |

## Verification
The state logic is exercised with queue 2 running alone and with queue 1 starting over a running, paused or idle queue 2. Together these cover all eleven status codes and separate suspension from pending. Triggers are sent in every condition and in software, off, external, timer and gated modes, so accepted triggers can be told apart from dropped overruns and from ignored pulses. The flag tests order reads and writes so that an armed clear, an unarmed clear, a write of 1 and a clear that collides with a new overrun each give a different flag value.

// File: rtl/scanq_ovr_pkg.sv
package scanq_ovr_pkg;
  localparam int NQ       = 2;
  localparam int MODE_W   = 3;
  localparam int STATUS_W = 4;
  localparam int REG_W    = 8;

  typedef enum logic [2:0] {
    QS_IDLE   = 3'd0,
    QS_ACTIVE = 3'd1,
    QS_PAUSED = 3'd2,
    QS_SUSP   = 3'd3,
    QS_PEND   = 3'd4
  } qstate_e;

  typedef enum logic [MODE_W-1:0] {
    M_OFF     = 3'd0,
    M_SW_ONE  = 3'd1,
    M_SW_RUN  = 3'd2,
    M_EXT_ONE = 3'd3,
    M_EXT_RUN = 3'd4,
    M_TMR_ONE = 3'd5,
    M_TMR_RUN = 3'd6,
    M_GATED   = 3'd7
  } qmode_e;

  function automatic logic mode_is_hw(input logic [MODE_W-1:0] m);
    return m >= MODE_W'(M_EXT_ONE);
  endfunction

  function automatic logic mode_is_sw(input logic [MODE_W-1:0] m);
    return (m == MODE_W'(M_SW_ONE)) || (m == MODE_W'(M_SW_RUN));
  endfunction
endpackage

// File: rtl/scanq_queue.sv
module scanq_queue
  import scanq_ovr_pkg::*;
#(
  parameter bit PRIMARY    = 1'b1,
  parameter int EOQ_REPEAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              trig_i,
  input  logic              start_i,
  input  logic              pause_i,
  input  logic              eoq_i,
  input  logic              stop_i,
  input  logic              hold_nxt_i,
  output qstate_e           state_nxt_o,
  output logic              ovr_evt_o
);
  localparam int CNT_W = $clog2(EOQ_REPEAT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(EOQ_REPEAT - 1);

  qstate_e state_q, state_d;
  logic [CNT_W-1:0] eoq_cnt_q, eoq_cnt_d;
  logic hw_mode, sw_mode, accept, busy, gated, rescan, trig_ovr, gate_ovr;

  always_comb begin
    hw_mode  = mode_is_hw(mode_i);
    sw_mode  = mode_is_sw(mode_i);
    accept   = (hw_mode & trig_i) | (sw_mode & start_i);
    busy     = (state_q == QS_ACTIVE) || (state_q == QS_SUSP) || (state_q == QS_PEND);
    gated    = PRIMARY && (mode_i == MODE_W'(M_GATED));
    rescan   = (mode_i == MODE_W'(M_SW_RUN)) || gated;
    trig_ovr = hw_mode & trig_i & busy;
    gate_ovr = gated & (state_q == QS_ACTIVE) & eoq_i & ~stop_i & (eoq_cnt_q >= CNT_TOP);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      QS_IDLE: begin
        if (accept) state_d = hold_nxt_i ? QS_PEND : QS_ACTIVE;
      end
      QS_ACTIVE: begin
        if (stop_i)                state_d = QS_IDLE;
        else if (eoq_i && !rescan) state_d = QS_IDLE;
        else if (pause_i)          state_d = QS_PAUSED;
        else if (hold_nxt_i)       state_d = QS_SUSP;
      end
      QS_PAUSED: begin
        if (stop_i)      state_d = QS_IDLE;
        else if (accept) state_d = hold_nxt_i ? QS_PEND : QS_ACTIVE;
      end
      QS_SUSP, QS_PEND: begin
        if (stop_i)           state_d = QS_IDLE;
        else if (!hold_nxt_i) state_d = QS_ACTIVE;
      end
      default: state_d = QS_IDLE;
    endcase
  end

  always_comb begin
    eoq_cnt_d = eoq_cnt_q;
    if (state_d == QS_IDLE)
      eoq_cnt_d = '0;
    else if (gated && state_q == QS_ACTIVE && eoq_i && eoq_cnt_q < CNT_TOP)
      eoq_cnt_d = eoq_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= QS_IDLE;
      eoq_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      eoq_cnt_q <= eoq_cnt_d;
    end
  end

  assign state_nxt_o = state_d;
  assign ovr_evt_o   = trig_ovr | gate_ovr;

  // R6: software, off modes never report an overrun
  a_r6_sw_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_is_hw(mode_i) |-> !ovr_evt_o);

  // R7: a dropped trigger leaves a running queue running
  a_r7_overrun_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == QS_ACTIVE && trig_i && mode_is_hw(mode_i) && !stop_i && !eoq_i
     && !pause_i && !hold_nxt_i) |=> (state_q == QS_ACTIVE));

  // R2: stop always lands in idle
  a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (state_q == QS_IDLE));

  generate
    if (PRIMARY) begin : g_prim
      // R3: the priority queue is never parked
      a_r3_primary_never_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q inside {QS_SUSP, QS_PEND}));
    end
  endgenerate
endmodule

// File: rtl/scanq_flag.sv
module scanq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q, clr_hit, flag_d, arm_d;

  always_comb begin
    clr_hit = wr_i & ~wbit_i & arm_q & flag_q;
    flag_d  = set_i | (flag_q & ~clr_hit);
    if (clr_hit || (set_i && !flag_q)) arm_d = 1'b0;
    else                               arm_d = arm_q | (rd_i & flag_q);
    arm_d = arm_d & flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R10: without an earlier read, a set flag survives
  a_r10_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !arm_q) |=> flag_q);

  // R11: a new overrun always leaves the flag set
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R9: armed write of 0 clears
  a_r9_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && arm_q && wr_i && !wbit_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/scanq_status.sv
module scanq_status
  import scanq_ovr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  qstate_e             q1_nxt_i,
  input  qstate_e             q2_nxt_i,
  output logic [STATUS_W-1:0] status_o
);
  localparam int HALF = STATUS_W / 2;

  logic [HALF-1:0] hi, lo;
  logic [STATUS_W-1:0] status_q;

  always_comb begin
    unique case (q1_nxt_i)
      QS_ACTIVE: hi = HALF'(2'b01);
      QS_PAUSED: hi = HALF'(2'b10);
      default:   hi = '0;
    endcase
    if (q1_nxt_i == QS_IDLE) begin
      unique case (q2_nxt_i)
        QS_ACTIVE: lo = HALF'(2'b01);
        QS_PAUSED: lo = HALF'(2'b10);
        default:   lo = '0;
      endcase
    end else begin
      unique case (q2_nxt_i)
        QS_PAUSED: lo = HALF'(2'b01);
        QS_SUSP:   lo = HALF'(2'b10);
        QS_PEND:   lo = HALF'(2'b11);
        default:   lo = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= {hi, lo};
  end

  assign status_o = status_q;

  // R3: queue 2 only runs while queue 1 is idle, and is only parked while queue 1 is busy
  a_r3_pair_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_nxt_i == QS_IDLE) ? !(q2_nxt_i inside {QS_SUSP, QS_PEND}) : (q2_nxt_i != QS_ACTIVE));

  // R4: reserved codes are never produced
  a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != 4'b0011) && (status_q[3:2] != 2'b11));
endmodule

// File: rtl/scanq_ovr_tracker.sv
module scanq_ovr_tracker
  import scanq_ovr_pkg::*;
#(
  parameter int EOQ_REPEAT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MODE_W-1:0]   q1_mode_i,
  input  logic [MODE_W-1:0]   q2_mode_i,
  input  logic [NQ-1:0]       trig_i,
  input  logic [NQ-1:0]       start_i,
  input  logic [NQ-1:0]       pause_i,
  input  logic [NQ-1:0]       eoq_i,
  input  logic [NQ-1:0]       stop_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [NQ-1:0]       wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic [STATUS_W-1:0] status_o,
  output logic [NQ-1:0]       ovr_o
);
  localparam int PAD_W = REG_W - STATUS_W - NQ;

  logic [MODE_W-1:0] mode_w [NQ];
  qstate_e           q_nxt  [NQ];
  logic [NQ-1:0]     ovr_evt;
  logic              q1_busy_nxt;

  assign mode_w[0]   = q1_mode_i;
  assign mode_w[1]   = q2_mode_i;
  assign q1_busy_nxt = (q_nxt[0] != QS_IDLE);

  generate
    for (genvar i = 0; i < NQ; i++) begin : g_q
      scanq_queue #(
        .PRIMARY    (i == 0),
        .EOQ_REPEAT (EOQ_REPEAT)
      ) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_w[i]),
        .trig_i      (trig_i[i]),
        .start_i     (start_i[i]),
        .pause_i     (pause_i[i]),
        .eoq_i       (eoq_i[i]),
        .stop_i      (stop_i[i]),
        .hold_nxt_i  ((i == 0) ? 1'b0 : q1_busy_nxt),
        .state_nxt_o (q_nxt[i]),
        .ovr_evt_o   (ovr_evt[i])
      );

      scanq_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ovr_evt[i]),
        .rd_i   (rd_i),
        .wr_i   (wr_i),
        .wbit_i (wdata_i[i]),
        .flag_o (ovr_o[i])
      );
    end
  endgenerate

  scanq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .q1_nxt_i (q_nxt[0]),
    .q2_nxt_i (q_nxt[1]),
    .status_o (status_o)
  );

  assign rdata_o = {status_o, {PAD_W{1'b0}}, ovr_o};

  // R12: read data mirrors status and flags
  a_r12_rdata_layout: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o[REG_W-1 -: STATUS_W] == status_o) && (rdata_o[NQ-1:0] == ovr_o));
endmodule

// File: tb/sim_scanq_ovr_tracker.sv
`timescale 1ns/1ps
module sim_scanq_ovr_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] q1_mode = 3'd0, q2_mode = 3'd0;
  logic [1:0] trig = '0, start = '0, pause = '0, eoq = '0, stop = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [1:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] status;
  logic [1:0] ovr;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scanq_ovr_tracker u0 (
    .clk(clk), .rst_n(rst_n), .q1_mode_i(q1_mode), .q2_mode_i(q2_mode),
    .trig_i(trig), .start_i(start), .pause_i(pause), .eoq_i(eoq), .stop_i(stop),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .status_o(status), .ovr_o(ovr)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ev(input logic [1:0] tg, input logic [1:0] st, input logic [1:0] pa,
                    input logic [1:0] eo, input logic [1:0] sp);
    trig = tg; start = st; pause = pa; eoq = eo; stop = sp;
    @(negedge clk);
    trig = '0; start = '0; pause = '0; eoq = '0; stop = '0;
  endtask

  task automatic bus_rd(output logic [7:0] d);
    rd = 1'b1;
    d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [1:0] d, input logic [1:0] tg);
    wr = 1'b1; wdata = d; trig = tg;
    @(negedge clk);
    wr = 1'b0; wdata = '0; trig = '0;
  endtask

  task automatic t_reset();
    chk("R1", "status", {4'h0, status}, 8'h00);
    chk("R1", "ovr", {6'h0, ovr}, 8'h00);
    chk("R12", "rdata", rdata, 8'h00);
  endtask

  task automatic t_sw_single();
    q1_mode = 3'd1;
    ev(2'b01, 0, 0, 0, 0);  chk("R6", "hw trig ignored in sw mode", {4'h0, status}, 8'h00);
    ev(0, 2'b01, 0, 0, 0);  chk("R2", "start -> active", {4'h0, status}, 8'h04);
    ev(0, 2'b01, 0, 0, 0);  chk("R6", "start while busy no flag", {6'h0, ovr}, 8'h00);
    ev(2'b01, 0, 0, 0, 0);  chk("R6", "trig while busy no flag", {6'h0, ovr}, 8'h00);
    ev(0, 0, 0, 2'b01, 0);  chk("R2", "eoq single -> idle", {4'h0, status}, 8'h00);
  endtask

  task automatic t_sw_cont();
    q2_mode = 3'd2;
    ev(0, 2'b10, 0, 0, 0);  chk("R4", "q2 active", {4'h0, status}, 8'h01);
    ev(0, 0, 0, 2'b10, 0);  chk("R2", "eoq continuous stays", {4'h0, status}, 8'h01);
    ev(0, 0, 2'b10, 0, 0);  chk("R4", "q2 paused", {4'h0, status}, 8'h02);
    ev(0, 2'b10, 0, 0, 0);  chk("R2", "start resumes", {4'h0, status}, 8'h01);
    ev(0, 0, 0, 0, 2'b10);  chk("R2", "stop -> idle", {4'h0, status}, 8'h00);
  endtask

  task automatic t_preempt();
    q1_mode = 3'd3; q2_mode = 3'd4;
    ev(2'b10, 0, 0, 0, 0);  chk("R2", "q2 trig -> active", {4'h0, status}, 8'h01);
    ev(2'b01, 0, 0, 0, 0);  chk("R3", "q2 suspended", {4'h0, status}, 8'h06);
    ev(0, 0, 2'b01, 0, 0);  chk("R4", "q1 paused q2 susp", {4'h0, status}, 8'h0A);
    ev(2'b01, 0, 0, 0, 0);  chk("R2", "q1 resumed", {4'h0, status}, 8'h06);
    chk("R5", "paused trig no flag", {6'h0, ovr}, 8'h00);
    ev(0, 0, 0, 2'b01, 0);  chk("R3", "q2 resumes", {4'h0, status}, 8'h01);
    ev(0, 0, 0, 2'b10, 0);  chk("R2", "hw eoq -> idle", {4'h0, status}, 8'h00);
  endtask

  task automatic t_encode();
    q1_mode = 3'd3; q2_mode = 3'd3;
    ev(2'b10, 0, 0, 0, 0);
    ev(0, 0, 2'b10, 0, 0);  chk("R4", "code 0010", {4'h0, status}, 8'h02);
    ev(2'b01, 0, 0, 0, 0);  chk("R4", "code 0101", {4'h0, status}, 8'h05);
    ev(0, 0, 2'b01, 0, 0);  chk("R4", "code 1001", {4'h0, status}, 8'h09);
    ev(2'b10, 0, 0, 0, 0);  chk("R3", "code 1011 pending", {4'h0, status}, 8'h0B);
    ev(0, 0, 0, 0, 2'b10);  chk("R4", "code 1000", {4'h0, status}, 8'h08);
    ev(2'b10, 0, 0, 0, 0);  chk("R3", "pending again", {4'h0, status}, 8'h0B);
    ev(0, 0, 0, 0, 2'b01);  chk("R3", "pending starts", {4'h0, status}, 8'h01);
    ev(0, 0, 0, 0, 2'b10);  chk("R4", "code 0000", {4'h0, status}, 8'h00);
  endtask

  task automatic t_overrun();
    q1_mode = 3'd3; q2_mode = 3'd4;
    ev(2'b01, 0, 0, 0, 0);  chk("R2", "q1 active", {4'h0, status}, 8'h04);
    ev(2'b10, 0, 0, 0, 0);  chk("R3", "q2 pending", {4'h0, status}, 8'h07);
    ev(2'b10, 0, 0, 0, 0);  chk("R5", "pending trig flags", {6'h0, ovr}, 8'h02);
    chk("R7", "state kept", {4'h0, status}, 8'h07);
    ev(2'b01, 0, 0, 0, 0);  chk("R5", "active trig flags q1", {6'h0, ovr}, 8'h03);
    chk("R7", "q1 kept active", {4'h0, status}, 8'h07);
    ev(0, 0, 0, 2'b01, 0);  chk("R3", "q2 starts", {4'h0, status}, 8'h01);
    ev(0, 0, 0, 2'b10, 0);  chk("R2", "q2 done", {4'h0, status}, 8'h00);
    ev(0, 0, 0, 0, 0);      chk("R7", "dropped trig not replayed", {4'h0, status}, 8'h00);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    bus_wr(2'b00, 0);       chk("R10", "unarmed write 0", {6'h0, ovr}, 8'h03);
    bus_wr(2'b11, 0);       chk("R10", "write 1", {6'h0, ovr}, 8'h03);
    bus_rd(d);              chk("R12", "rdata flags", d, 8'h03);
    bus_wr(2'b10, 0);       chk("R9", "clear q1 only", {6'h0, ovr}, 8'h02);
    bus_wr(2'b00, 0);       chk("R9", "clear q2", {6'h0, ovr}, 8'h00);
  endtask

  task automatic t_paused_ok();
    q2_mode = 3'd3;
    ev(2'b10, 0, 0, 0, 0);  chk("R2", "q2 active", {4'h0, status}, 8'h01);
    ev(0, 0, 2'b10, 0, 0);  chk("R2", "q2 paused", {4'h0, status}, 8'h02);
    ev(2'b10, 0, 0, 0, 0);  chk("R5", "paused trig accepted", {4'h0, status}, 8'h01);
    chk("R5", "no flag from paused", {6'h0, ovr}, 8'h00);
    ev(2'b10, 0, 0, 0, 0);  chk("R5", "active trig flags", {6'h0, ovr}, 8'h02);
    ev(0, 0, 0, 0, 2'b10);  chk("R2", "stop", {4'h0, status}, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    ev(2'b10, 0, 0, 0, 0);
    bus_rd(d);              chk("R12", "rdata status+flag", d, 8'h12);
    bus_wr(2'b00, 2'b10);   chk("R11", "set beats clear", {6'h0, ovr}, 8'h02);
    bus_wr(2'b00, 0);       chk("R11", "rearm needed", {6'h0, ovr}, 8'h02);
    bus_rd(d);
    bus_wr(2'b00, 0);       chk("R9", "clear after reread", {6'h0, ovr}, 8'h00);
    ev(0, 0, 0, 0, 2'b10);
  endtask

  task automatic t_gated();
    logic [7:0] d;
    q1_mode = 3'd7;
    ev(2'b01, 0, 0, 0, 0);  chk("R2", "gated active", {4'h0, status}, 8'h04);
    ev(0, 0, 0, 2'b01, 0);  chk("R8", "first eoq no flag", {6'h0, ovr}, 8'h00);
    chk("R2", "gated stays active", {4'h0, status}, 8'h04);
    ev(0, 0, 0, 2'b01, 0);  chk("R8", "second eoq flags", {6'h0, ovr}, 8'h01);
    ev(0, 0, 0, 2'b01, 0);  chk("R8", "third eoq still active", {4'h0, status}, 8'h04);
    ev(0, 0, 0, 0, 2'b01);
    bus_rd(d);
    bus_wr(2'b00, 0);       chk("R9", "gated flag cleared", {6'h0, ovr}, 8'h00);
    ev(2'b01, 0, 0, 0, 0);
    ev(0, 0, 0, 2'b01, 0);  chk("R8", "count restarted", {6'h0, ovr}, 8'h00);
    ev(0, 0, 0, 0, 2'b01);
  endtask

  task automatic t_modes();
    q2_mode = 3'd0;
    ev(2'b10, 2'b10, 0, 0, 0); chk("R6", "off mode ignores all", {4'h0, status}, 8'h00);
    q1_mode = 3'd5;
    ev(0, 2'b01, 0, 0, 0);  chk("R6", "start ignored in hw mode", {4'h0, status}, 8'h00);
    q2_mode = 3'd6;
    ev(2'b10, 0, 0, 0, 0);  chk("R2", "timer trig starts", {4'h0, status}, 8'h01);
    ev(2'b10, 0, 0, 0, 0);  chk("R5", "timer overrun", {6'h0, ovr}, 8'h02);
    ev(0, 0, 0, 0, 2'b10);  chk("R2", "stop", {4'h0, status}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sw_single();
    t_sw_cont();
    t_preempt();
    t_encode();
    t_overrun();
    t_clear();
    t_paused_ok();
    t_collide();
    t_gated();
    t_modes();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule